// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between instruction fetch and decode. Fetch delivers code as 64-bit lines. Inside a line, 16-bit, 32-bit and 64-bit opcodes are packed back to back with no padding, so an opcode may begin in one line and end in the next. The aligner keeps the 16-bit parcels it has received in a staging buffer. It works out the length of the oldest opcode from its first parcel. Once every parcel of that opcode is present, it hands the opcode to decode left-justified in a 64-bit word, together with a length code. A 64-bit opcode is a bundle of one 32-bit and two 16-bit instructions, and it always leaves as a single unit.

Fetch pushes lines through a valid/ready handshake, and decode pulls opcodes through a second valid/ready handshake. A flush input, used on redirects, drops every buffered parcel. It also loads a start offset, so the first line fetched after the redirect can begin at any of its four parcels.

Top module: `insn_aligner`

## Requirements
- R1: After reset the buffer is empty: `line_ready_o` is 1 and `ins_valid_o` is 0.
- R2: The length comes from the first parcel of an opcode. If parcel bits [15:14] are not `11`, the opcode is 16-bit and `ins_len_o` is 0. If they are `11` and bit 13 is 0, it is 32-bit and `ins_len_o` is 1. If they are `11` and bit 13 is 1, it is a 64-bit bundle and `ins_len_o` is 2.
- R3: The first parcel of the opcode appears on `ins_data_o[63:48]`, and each later parcel sits in the next lower 16 bits. Bits below the opcode are zero.
- R4: Opcodes are issued in the order they are packed. Within a line, parcel 0 is `line_data_i[15:0]` and comes first, and parcel 3 is `line_data_i[63:48]`.
- R5: An opcode that crosses a line boundary is issued whole once its remaining parcels arrive. Until then `ins_valid_o` stays 0.
- R6: `line_ready_o` is 1 exactly when flush is low and at most 4 parcels are buffered.
- R7: While `ins_valid_o` is 1 and `ins_ready_i` is 0, `ins_data_o` and `ins_len_o` hold their values into the next cycle.
- R8: In a flush cycle both `ins_valid_o` and `line_ready_o` are 0. After that cycle the buffer is empty.
- R9: The first line accepted after a flush drops its `flush_off_i` leading parcels. Later lines are taken whole.
- R10: A line can be accepted and an opcode issued in the same cycle, and neither parcel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Drop all buffered parcels and load the start offset |
| flush_off_i | input | 2 | Number of leading parcels to skip in the first line after a flush |
| line_valid_i | input | 1 | A fetch line is offered |
| line_ready_o | output | 1 | The aligner can take a fetch line |
| line_data_i | input | 64 | Fetch line; parcel 0 is in the low bits |
| ins_valid_o | output | 1 | A complete opcode is presented |
| ins_ready_i | input | 1 | Decode takes the presented opcode |
| ins_data_o | output | 64 | Opcode, left-justified, zero-filled |
| ins_len_o | output | 2 | Length code: 0 = 16, 1 = 32, 2 = 64 bits |

## Verification
The buffer is a register, and both handshake outputs are combinational from it and from flush. A line taken at a rising edge therefore changes `ins_valid_o`, `ins_data_o` and `line_ready_o` in the cycle that starts at that edge. Flush forces both valid outputs low in its own cycle. The bench drives inputs on the falling edge and samples outputs 1 ns later. In that window it decides whether a transfer will happen at the next rising edge, so every expected opcode is compared in the cycle in which it is handed over. Backpressure on both sides is random, and the expected opcode sequence is built from the packed parcel stream and nothing else.

// File: rtl/insn_align_pkg.sv
// Shared types for the instruction aligner.
package insn_align_pkg;
    // Opcode length as seen by decode
    typedef enum logic [1:0] {
        LEN_16 = 2'd0,
        LEN_32 = 2'd1,
        LEN_64 = 2'd2
    } len_code_e;
endpackage

// File: rtl/ia_len_decode.sv
// Length decoder: classifies an opcode from its first parcel.
// Assumes the two top parcel bits flag a long opcode and BUNDLE_BIT
// separates 32-bit opcodes from 64-bit bundles.
module ia_len_decode
    import insn_align_pkg::*;
#(
    parameter int PW         = 16,
    parameter int BUNDLE_BIT = 13,
    parameter int CNT_W      = 4
) (
    input  logic [PW-1:0]    head_i,
    output len_code_e        len_o,
    output logic [CNT_W-1:0] nparc_o
);
    // Map the head parcel to a length code and a parcel count
    always_comb begin
        if (head_i[PW-1:PW-2] != 2'b11) begin
            len_o   = LEN_16;
            nparc_o = CNT_W'(1);
        end else if (!head_i[BUNDLE_BIT]) begin
            len_o   = LEN_32;
            nparc_o = CNT_W'(2);
        end else begin
            len_o   = LEN_64;
            nparc_o = CNT_W'(4);
        end
    end
endmodule

// File: rtl/ia_line_unpack.sv
// Line unpacker: drops leading parcels of a fetch line and returns the
// remaining parcels, packed toward parcel 0, with their count.
// Assumes parcel 0 occupies the low bits of the line.
module ia_line_unpack #(
    parameter int PW     = 16,
    parameter int LINE_P = 4,
    parameter int CNT_W  = 4,
    parameter int SKIP_W = $clog2(LINE_P)
) (
    input  logic [LINE_P*PW-1:0] line_i,
    input  logic [SKIP_W-1:0]    skip_i,
    output logic [LINE_P*PW-1:0] parcels_o,
    output logic [CNT_W-1:0]     count_o
);
    // Shift out skipped parcels; zeros fill the vacated top
    always_comb begin
        parcels_o = line_i >> (skip_i * PW);
        count_o   = CNT_W'(LINE_P) - CNT_W'(skip_i);
    end
endmodule

// File: rtl/ia_stage_buf.sv
// Staging buffer: a parcel queue with the oldest parcel at the low end.
// Each cycle it pops a whole opcode and appends the parcels of a line.
// Assumes the caller pushes only when the parcels fit, and pops no more
// parcels than it holds. Slots above the count are kept at zero.
module ia_stage_buf #(
    parameter int PW     = 16,
    parameter int BUF_P  = 8,
    parameter int LINE_P = 4,
    parameter int CNT_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 push_i,
    input  logic [LINE_P*PW-1:0] push_data_i,
    input  logic [CNT_W-1:0]     push_cnt_i,
    input  logic                 pop_i,
    input  logic [CNT_W-1:0]     pop_cnt_i,
    output logic [BUF_P*PW-1:0]  data_o,
    output logic [CNT_W-1:0]     cnt_o
);
    localparam int BUF_W = BUF_P * PW;

    logic [BUF_W-1:0] data_q, data_d, kept, push_ext;
    logic [CNT_W-1:0] cnt_q, cnt_d, pop_eff, base;

    // Remove the issued opcode, then append incoming parcels after the rest
    always_comb begin
        pop_eff  = pop_i ? pop_cnt_i : '0;
        kept     = data_q >> (pop_eff * PW);
        base     = cnt_q - pop_eff;
        push_ext = BUF_W'(push_data_i);
        data_d   = kept | (push_i ? (push_ext << (base * PW)) : '0);
        cnt_d    = base + (push_i ? push_cnt_i : '0);
    end

    // Hold queue contents and count; reset and flush empty it
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else begin
            data_q <= data_d;
            cnt_q  <= cnt_d;
        end
    end

    assign data_o = data_q;
    assign cnt_o  = cnt_q;

    // R6: the buffer never holds more parcels than it has slots
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BUF_P));

    // R6: a push arrives only when the whole line fits
    a_r6_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q + push_cnt_i <= CNT_W'(BUF_P)));

    // R5: an opcode is popped only when all of its parcels are present
    a_r5_pop_complete: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (pop_cnt_i <= cnt_q));

    // R8: a flush leaves the buffer empty
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/insn_aligner.sv
// Variable-length instruction aligner (top).
// Takes 64-bit fetch lines of densely packed 16/32/64-bit opcodes and
// issues one whole opcode per handshake, left-justified with a length code.
// Assumes the first parcel of the stream after a flush is at flush_off_i.
module insn_aligner
    import insn_align_pkg::*;
#(
    parameter int LINE_W     = 64,
    parameter int PARCEL_W   = 16,
    parameter int BUF_LINES  = 2,
    parameter int BUNDLE_BIT = 13
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush_i,
    input  logic [$clog2(LINE_W/PARCEL_W)-1:0] flush_off_i,
    input  logic                              line_valid_i,
    output logic                              line_ready_o,
    input  logic [LINE_W-1:0]                 line_data_i,
    output logic                              ins_valid_o,
    input  logic                              ins_ready_i,
    output logic [4*PARCEL_W-1:0]             ins_data_o,
    output logic [1:0]                        ins_len_o
);
    localparam int LINE_P  = LINE_W / PARCEL_W;
    localparam int BUF_P   = BUF_LINES * LINE_P;
    localparam int CNT_W   = $clog2(BUF_P + 1);
    localparam int SKIP_W  = $clog2(LINE_P);
    localparam int MAXOP_P = 4;
    localparam int OUT_W   = MAXOP_P * PARCEL_W;

    logic [SKIP_W-1:0]          skip_q;
    logic [LINE_W-1:0]          in_parcels;
    logic [CNT_W-1:0]           in_cnt;
    logic [BUF_P*PARCEL_W-1:0]  buf_data;
    logic [CNT_W-1:0]           buf_cnt;
    logic [CNT_W-1:0]           head_nparc;
    len_code_e                  head_len;
    logic                       push, pop;

    ia_line_unpack #(
        .PW(PARCEL_W), .LINE_P(LINE_P), .CNT_W(CNT_W), .SKIP_W(SKIP_W)
    ) u_unpack (
        .line_i    (line_data_i),
        .skip_i    (skip_q),
        .parcels_o (in_parcels),
        .count_o   (in_cnt)
    );

    ia_len_decode #(
        .PW(PARCEL_W), .BUNDLE_BIT(BUNDLE_BIT), .CNT_W(CNT_W)
    ) u_len (
        .head_i  (buf_data[PARCEL_W-1:0]),
        .len_o   (head_len),
        .nparc_o (head_nparc)
    );

    ia_stage_buf #(
        .PW(PARCEL_W), .BUF_P(BUF_P), .LINE_P(LINE_P), .CNT_W(CNT_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .push_i      (push),
        .push_data_i (in_parcels),
        .push_cnt_i  (in_cnt),
        .pop_i       (pop),
        .pop_cnt_i   (head_nparc),
        .data_o      (buf_data),
        .cnt_o       (buf_cnt)
    );

    // Handshakes: fetch needs a free line's worth of slots, issue needs a whole opcode
    always_comb begin
        line_ready_o = !flush_i && (buf_cnt <= CNT_W'(BUF_P - LINE_P));
        ins_valid_o  = !flush_i && (buf_cnt >= head_nparc);
        push         = line_valid_i && line_ready_o;
        pop          = ins_valid_o && ins_ready_i;
        ins_len_o    = head_len;
    end

    // Left-justify the head opcode, zeroing parcels beyond its length
    for (genvar k = 0; k < MAXOP_P; k++) begin : g_out
        assign ins_data_o[OUT_W-1-k*PARCEL_W -: PARCEL_W] =
            (CNT_W'(k) < head_nparc) ? buf_data[k*PARCEL_W +: PARCEL_W] : '0;
    end

    // Start offset: loaded by flush, used by the first line accepted afterwards
    always_ff @(posedge clk) begin
        if (!rst_n)       skip_q <= '0;
        else if (flush_i) skip_q <= flush_off_i;
        else if (push)    skip_q <= '0;
    end

    // R7: a stalled opcode holds still until taken or flushed
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_o && !ins_ready_i && !flush_i) |=>
        (flush_i || (ins_valid_o && $stable(ins_data_o) && $stable(ins_len_o))));

    // R3: a 16-bit opcode leaves the lower 48 bits zero
    a_r3_short_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_o && ins_len_o == 2'd0) |-> (ins_data_o[OUT_W-PARCEL_W-1:0] == '0));

    // R9: the start offset is spent by the first accepted line
    a_r9_offset_once: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush_i) |=> (flush_i || skip_q == '0));
endmodule

// File: tb/insn_aligner_bench.sv
module insn_aligner_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  off = '0;
    logic        lv = 1'b0;
    logic        ready;
    logic [63:0] ld = '0;
    logic        iv;
    logic        ir = 1'b0;
    logic [63:0] id;
    logic [1:0]  il;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    insn_aligner u_insn_aligner (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .flush_off_i(off),
        .line_valid_i(lv), .line_ready_o(ready), .line_data_i(ld),
        .ins_valid_o(iv), .ins_ready_i(ir), .ins_data_o(id), .ins_len_o(il)
    );

    // Vector table: one line after a flush with an offset, and the first opcode expected
    localparam int NT = 10;
    localparam logic [63:0] T_LINE [NT] = '{
        64'h3333_2222_1111_1234, 64'h3333_2222_ABCD_C001, 64'h3333_2222_1111_E002,
        64'h3333_2222_8055_FFFF, 64'hC0FF_2222_1111_FFFF, 64'h3333_E123_1111_FFFF,
        64'h5A5A_D000_1111_FFFF, 64'h4000_2222_1111_FFFF, 64'h3333_2222_1111_3FFF,
        64'h3333_2222_1111_7FFF };
    localparam logic [1:0] T_OFF [NT] = '{0, 0, 0, 1, 3, 2, 2, 3, 0, 0};
    localparam bit T_V [NT] = '{1, 1, 1, 1, 0, 0, 1, 1, 1, 1};
    localparam logic [63:0] T_D [NT] = '{
        64'h1234_0000_0000_0000, 64'hC001_ABCD_0000_0000, 64'hE002_1111_2222_3333,
        64'h8055_0000_0000_0000, 64'h0, 64'h0, 64'hD000_5A5A_0000_0000,
        64'h4000_0000_0000_0000, 64'h3FFF_0000_0000_0000, 64'h7FFF_0000_0000_0000 };
    localparam logic [1:0] T_L [NT] = '{0, 1, 2, 0, 0, 0, 1, 0, 0, 0};

    logic [15:0] ps [0:1023];
    logic [63:0] ed [0:1023];
    logic [1:0]  el [0:1023];
    logic [63:0] lines [0:255];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic do_flush(input logic [1:0] o);
        @(negedge clk);
        flush = 1'b1; off = o; lv = 1'b0; ir = 1'b0;
        #1;
        chk(!iv && !ready, "R8 flush cycle quiet", {62'b0, iv, ready}, 64'h0);
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Random packed stream, optional skipped lead parcels, random backpressure both sides
    task automatic run_stream(input int lead);
        int np = 0, ne = 0, nl, li = 0, k = 0, both = 0, cyc = 0;
        for (int j = 0; j < lead; j++) begin ps[np] = 16'hFFFF; np++; end
        while (np < 600) begin
            int kind = $urandom_range(0, 2);
            logic [15:0] a = 16'($urandom), b = 16'($urandom), c = 16'($urandom), d = 16'($urandom);
            if (kind == 0) begin
                a[14] = 1'b0;
                ps[np] = a; np++;
                ed[ne] = {a, 48'h0}; el[ne] = 2'd0; ne++;
            end else if (kind == 1) begin
                a[15:13] = 3'b110;
                ps[np] = a; ps[np+1] = b; np += 2;
                ed[ne] = {a, b, 32'h0}; el[ne] = 2'd1; ne++;
            end else begin
                a[15:13] = 3'b111;
                ps[np] = a; ps[np+1] = b; ps[np+2] = c; ps[np+3] = d; np += 4;
                ed[ne] = {a, b, c, d}; el[ne] = 2'd2; ne++;
            end
        end
        while (np % 4 != 0) begin ps[np] = 16'h0000; np++; ed[ne] = 64'h0; el[ne] = 2'd0; ne++; end
        nl = np / 4;
        for (int j = 0; j < nl; j++) lines[j] = {ps[4*j+3], ps[4*j+2], ps[4*j+1], ps[4*j]};
        do_flush(2'(lead));
        while (k < ne && cyc < 20000) begin
            lv = (li < nl) && ($urandom_range(0, 3) != 0);
            ld = lines[li < nl ? li : 0];
            ir = ($urandom_range(0, 2) != 0);
            #1;
            if (lv && ready && iv && ir) both++;
            if (lv && ready) li++;
            if (iv && ir) begin
                // R4 order, R2 length, R5 straddle reassembly, R9 lead skip
                chk(id == ed[k] && il == el[k], "R4 stream opcode", {id[63:2], il}, {ed[k][63:2], el[k]});
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        chk(k == ne, "R4 all opcodes issued", 64'(k), 64'(ne));
        chk(both > 0, "R10 concurrent accept and issue", 64'(both), 64'h1);
        lv = 1'b0; ir = 1'b0;
        #1;
        chk(!iv, "R4 nothing left over", {63'b0, iv}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ready && !iv, "R1 reset state", {62'b0, ready, iv}, 64'h2);

        // Table walk: R2 decode, R3 layout, R9 offsets, R5 incomplete head
        for (int i = 0; i < NT; i++) begin
            do_flush(T_OFF[i]);
            lv = 1'b1; ld = T_LINE[i];
            #1;
            chk(ready, "R6 ready when empty", {63'b0, ready}, 64'h1);
            @(negedge clk);
            lv = 1'b0;
            #1;
            chk(iv == T_V[i], "R5 valid only when complete", {63'b0, iv}, {63'b0, T_V[i]});
            if (T_V[i]) begin
                chk(id == T_D[i], "R3 left-justified data (R9 offset)", id, T_D[i]);
                chk(il == T_L[i], "R2 length code", {62'b0, il}, {62'b0, T_L[i]});
            end
        end

        // R5: 32-bit opcode split across two lines
        do_flush(2'd3);
        lv = 1'b1; ld = 64'hC0FF_2222_1111_FFFF;
        @(negedge clk);
        ld = 64'h0003_0002_0001_BEEF;
        #1;
        chk(!iv, "R5 half opcode held back", {63'b0, iv}, 64'h0);
        @(negedge clk);
        lv = 1'b0;
        #1;
        chk(iv && id == 64'hC0FF_BEEF_0000_0000 && il == 2'd1, "R5 straddle reassembled", id, 64'hC0FF_BEEF_0000_0000);
        ir = 1'b1;
        @(negedge clk);
        ir = 1'b0;
        #1;
        chk(iv && id == 64'h0001_0000_0000_0000, "R4 next parcel after straddle", id, 64'h0001_0000_0000_0000);

        // R6 fill level and R7 stall hold
        do_flush(2'd0);
        lv = 1'b1; ld = 64'h0044_0033_0022_0011;
        @(negedge clk);
        ld = 64'h0088_0077_0066_0055;
        #1;
        chk(ready, "R6 ready with four parcels", {63'b0, ready}, 64'h1);
        @(negedge clk);
        lv = 1'b0;
        #1;
        chk(!ready, "R6 not ready with eight parcels", {63'b0, ready}, 64'h0);
        for (int s = 0; s < 3; s++) begin
            chk(iv && id == 64'h0011_0000_0000_0000 && il == 2'd0, "R7 held under stall", id, 64'h0011_0000_0000_0000);
            @(negedge clk);
            #1;
        end
        ir = 1'b1;
        for (int s = 1; s <= 4; s++) begin
            @(negedge clk);
            #1;
            chk(id == {16'(16'h0011 * (s + 1)), 48'h0}, "R4 in-line order", id, {16'(16'h0011 * (s + 1)), 48'h0});
            chk(ready == (s == 4), "R6 ready returns at four", {63'b0, ready}, {63'b0, s == 4});
        end
        ir = 1'b0;

        // R8: flush drops a non-empty buffer
        do_flush(2'd0);
        #1;
        chk(!iv && ready, "R8 buffer empty after flush", {62'b0, iv, ready}, 64'h1);

        // Random streams: aligned start, then a start two parcels into the line (R9)
        run_stream(0);
        run_stream(2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule